// File: doc/BRIEF.md
# Parallel NOR Flash Identification and Sector Address Mapper

This block finds out which parallel NOR flash device is attached and then turns sector numbers into byte start addresses. It runs once on its own after reset, and again each time `probeReq` is pulsed while it is idle. A probe writes a three-step command sequence that switches the flash into its identification mode. It then waits a programmable number of cycles and reads the manufacturer byte. The device byte is read only if the manufacturer byte matches. Last, the block writes a read-mode command so the flash leaves identification mode.

Two device geometries are recognised. The boot-block part has four small leading sectors followed by 64 KiB sectors. The uniform part has only 64 KiB sectors. When the identification succeeds, the block holds a known flag, the sector count and the total size. A purely combinational lookup port then maps a sector index to its start address. That address includes a base offset, which depends on the geometry and on the `lowBoot` strap. An index outside the device returns valid low.

The flash side is a simple synchronous bus. A write strobe carries address and data in one cycle. A read strobe carries the address, and the flash must return the byte on `flashRdData` at the next clock edge.

Top module: `flash_probe_map`

## Requirements
- R1: Every probe writes exactly these three commands on consecutive cycles, in this order: byte 0xAA to offset 0xAAA, then 0x55 to offset 0x555, then 0x90 to offset 0xAAA.
- R2: More than WAIT_CYCLES clock cycles separate the 0x90 write from the manufacturer read. That read is a single read strobe at offset 0, and all 8 bits of `flashRdData` are compared with MFR_ID.
- R3: The device byte is read at offset 2, once per probe, and only when the manufacturer byte equals MFR_ID. Otherwise offset 2 is never read.
- R4: An unexpected manufacturer byte, or a device byte equal to neither DEV_BOOT_ID nor DEV_UNI_ID, leaves `devKnown`=0, `sectCount`=0 and `devSize`=0, and every lookup is invalid.
- R5: DEV_BOOT_ID gives `devKnown`=1, `sectCount`=35 and `devSize`=0x200000.
- R6: On the boot-block part, sectors 0 to 3 start at relative offsets 0x0000, 0x4000, 0x6000 and 0x8000. A sector i≥4 starts at 0x10000·(i−3).
- R7: DEV_UNI_ID gives `devKnown`=1, `sectCount`=128 and `devSize`=0x800000, and sector i starts at relative offset 0x10000·i.
- R8: `sectAddr` is the relative offset plus a base. The base is 0 when `lowBoot`=1. When `lowBoot`=0 it is 0xE00000 for the boot-block part and 0x800000 for the uniform part.
- R9: Each probe ends with a write of 0xF0 to offset 0. `busy` is low from the cycle after that write.
- R10: When `sectIdx` ≥ `sectCount` or `devKnown`=0, `sectValid`=0 and `sectAddr`=0.
- R11: A probe starts by itself one cycle after reset is released. `probeReq` pulses while `busy`=1 are ignored, so only one 0x90 command is written per probe. From the first busy cycle the previous result is cleared (`devKnown`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| probeReq | input | 1 | Start a new probe when idle |
| lowBoot | input | 1 | 1 selects a zero base offset |
| sectIdx | input | CNT_W | Sector index to look up |
| flashRdData | input | 8 | Byte returned by the flash one cycle after a read strobe |
| flashAddr | output | ADDR_W | Flash byte offset for the current strobe |
| flashWrData | output | 8 | Command byte written |
| flashWrEn | output | 1 | Write strobe |
| flashRdEn | output | 1 | Read strobe |
| busy | output | 1 | Probe in progress |
| devKnown | output | 1 | A supported device was identified |
| sectCount | output | CNT_W | Number of sectors, 0 if unknown |
| devSize | output | ADDR_W | Device size in bytes, 0 if unknown |
| sectValid | output | 1 | `sectIdx` names an existing sector |
| sectAddr | output | ADDR_W | Start address of sector `sectIdx` |

## Verification
The lookup port and a running probe can be active in the same cycle. A lookup issued while a re-probe is under way must not return the previous device's addresses. The bench provokes this by starting a probe and, in the first busy cycles, presenting a sector index that was valid a moment before. In those same cycles it pulses `probeReq` again. It judges the result from the ports: the lookup must be invalid with a zero address, and the flash model must log exactly one 0x90 command and one closing 0xF0 for that probe.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

  localparam int FL_DW = 8;

  localparam logic [FL_DW-1:0] CMD_KEY_A   = 8'hAA;
  localparam logic [FL_DW-1:0] CMD_KEY_B   = 8'h55;
  localparam logic [FL_DW-1:0] CMD_IDENT   = 8'h90;
  localparam logic [FL_DW-1:0] CMD_RDARRAY = 8'hF0;

  localparam int OFS_KEY_A = 'hAAA;
  localparam int OFS_KEY_B = 'h555;
  localparam int OFS_MFR   = 0;
  localparam int OFS_DEV   = 2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_KEYA,
    ST_KEYB,
    ST_IDENT,
    ST_WAIT,
    ST_RDMFR,
    ST_CAPMFR,
    ST_RDDEV,
    ST_CAPDEV,
    ST_EXIT
  } probeState_e;

  typedef struct packed {
    logic clrId;
    logic capDev;
  } idStrobe_t;

endpackage

// File: rtl/probe_ctrl.sv
module probe_ctrl
  import flash_probe_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int WAIT_CYCLES = 100
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                probeReq,
  input  logic                mfrOk,
  output idStrobe_t           strobe,
  output logic [ADDR_W-1:0]   flashAddr,
  output logic [FL_DW-1:0]    flashWrData,
  output logic                flashWrEn,
  output logic                flashRdEn,
  output logic                busy
);

  localparam int WAIT_W = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_CYCLES - 1);

  probeState_e state, stateNxt;
  logic [WAIT_W-1:0] waitCnt;
  logic pending;
  logic startProbe;

  assign startProbe = (state == ST_IDLE) && (pending || probeReq);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:   if (startProbe) stateNxt = ST_KEYA;
      ST_KEYA:   stateNxt = ST_KEYB;
      ST_KEYB:   stateNxt = ST_IDENT;
      ST_IDENT:  stateNxt = ST_WAIT;
      ST_WAIT:   if (waitCnt == WAIT_LAST) stateNxt = ST_RDMFR;
      ST_RDMFR:  stateNxt = ST_CAPMFR;
      ST_CAPMFR: stateNxt = mfrOk ? ST_RDDEV : ST_EXIT;
      ST_RDDEV:  stateNxt = ST_CAPDEV;
      ST_CAPDEV: stateNxt = ST_EXIT;
      ST_EXIT:   stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= 1'b1;
      waitCnt <= '0;
    end else begin
      state <= stateNxt;
      if (startProbe) pending <= 1'b0;
      if (state == ST_WAIT) waitCnt <= waitCnt + 1'b1;
      else                  waitCnt <= '0;
    end
  end

  always_comb begin
    flashAddr    = '0;
    flashWrData  = '0;
    flashWrEn    = 1'b0;
    flashRdEn    = 1'b0;
    strobe       = '0;
    strobe.clrId = startProbe;
    unique case (state)
      ST_KEYA: begin
        flashWrEn = 1'b1; flashAddr = ADDR_W'(OFS_KEY_A); flashWrData = CMD_KEY_A;
      end
      ST_KEYB: begin
        flashWrEn = 1'b1; flashAddr = ADDR_W'(OFS_KEY_B); flashWrData = CMD_KEY_B;
      end
      ST_IDENT: begin
        flashWrEn = 1'b1; flashAddr = ADDR_W'(OFS_KEY_A); flashWrData = CMD_IDENT;
      end
      ST_RDMFR: begin
        flashRdEn = 1'b1; flashAddr = ADDR_W'(OFS_MFR);
      end
      ST_RDDEV: begin
        flashRdEn = 1'b1; flashAddr = ADDR_W'(OFS_DEV);
      end
      ST_CAPDEV: strobe.capDev = 1'b1;
      ST_EXIT: begin
        flashWrEn = 1'b1; flashAddr = ADDR_W'(OFS_MFR); flashWrData = CMD_RDARRAY;
      end
      default: ;
    endcase
  end

  assign busy = (state != ST_IDLE);

  AST_KEY_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (flashWrEn && flashWrData == CMD_KEY_B) |-> $past(flashWrEn && flashWrData == CMD_KEY_A)); // R1

  AST_DEV_AFTER_MFR: assert property (@(posedge clk) disable iff (!rstN)
    (flashRdEn && flashAddr == ADDR_W'(OFS_DEV)) |-> $past(mfrOk)); // R3

  AST_EXIT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (flashWrEn && flashWrData == CMD_RDARRAY) |=> !busy); // R9

endmodule

// File: rtl/probe_dpath.sv
module probe_dpath
  import flash_probe_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int CNT_W       = 8,
  parameter int SECT_LOG2   = 16,
  parameter int BOOT_SECTS  = 35,
  parameter int UNI_SECTS   = 128,
  parameter logic [FL_DW-1:0] MFR_ID      = 8'h01,
  parameter logic [FL_DW-1:0] DEV_BOOT_ID = 8'h49,
  parameter logic [FL_DW-1:0] DEV_UNI_ID  = 8'hC8,
  parameter logic [ADDR_W-1:0] HIGH_BASE_BOOT = 24'hE00000,
  parameter logic [ADDR_W-1:0] HIGH_BASE_UNI  = 24'h800000
) (
  input  logic               clk,
  input  logic               rstN,
  input  idStrobe_t          strobe,
  input  logic [FL_DW-1:0]   flashRdData,
  input  logic               lowBoot,
  input  logic [CNT_W-1:0]   sectIdx,
  output logic               mfrOk,
  output logic               devKnown,
  output logic [CNT_W-1:0]   sectCount,
  output logic [ADDR_W-1:0]  devSize,
  output logic               sectValid,
  output logic [ADDR_W-1:0]  sectAddr
);

  localparam logic [ADDR_W-1:0] BOOT_SIZE = ADDR_W'((BOOT_SECTS - 3) << SECT_LOG2);
  localparam logic [ADDR_W-1:0] UNI_SIZE  = ADDR_W'(UNI_SECTS << SECT_LOG2);
  localparam logic [ADDR_W-1:0] SMALL1    = ADDR_W'(1 << (SECT_LOG2 - 2));
  localparam logic [ADDR_W-1:0] SMALL2    = ADDR_W'(3 << (SECT_LOG2 - 3));
  localparam logic [ADDR_W-1:0] SMALL3    = ADDR_W'(1 << (SECT_LOG2 - 1));

  logic isBoot;
  logic [ADDR_W-1:0] relOfs, baseOfs;

  assign mfrOk = (flashRdData == MFR_ID);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devKnown  <= 1'b0;
      isBoot    <= 1'b0;
      sectCount <= '0;
      devSize   <= '0;
    end else if (strobe.clrId) begin
      devKnown  <= 1'b0;
      isBoot    <= 1'b0;
      sectCount <= '0;
      devSize   <= '0;
    end else if (strobe.capDev) begin
      if (flashRdData == DEV_BOOT_ID) begin
        devKnown  <= 1'b1;
        isBoot    <= 1'b1;
        sectCount <= CNT_W'(BOOT_SECTS);
        devSize   <= BOOT_SIZE;
      end else if (flashRdData == DEV_UNI_ID) begin
        devKnown  <= 1'b1;
        isBoot    <= 1'b0;
        sectCount <= CNT_W'(UNI_SECTS);
        devSize   <= UNI_SIZE;
      end
    end
  end

  always_comb begin
    if (isBoot) begin
      unique case (sectIdx)
        CNT_W'(0): relOfs = '0;
        CNT_W'(1): relOfs = SMALL1;
        CNT_W'(2): relOfs = SMALL2;
        CNT_W'(3): relOfs = SMALL3;
        default:   relOfs = ADDR_W'(sectIdx - CNT_W'(3)) << SECT_LOG2;
      endcase
    end else begin
      relOfs = ADDR_W'(sectIdx) << SECT_LOG2;
    end
    if (lowBoot)     baseOfs = '0;
    else if (isBoot) baseOfs = HIGH_BASE_BOOT;
    else             baseOfs = HIGH_BASE_UNI;
  end

  assign sectValid = devKnown && (sectIdx < sectCount);
  assign sectAddr  = sectValid ? (baseOfs + relOfs) : '0;

  AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !devKnown |-> (sectCount == '0 && devSize == '0)); // R4

  AST_LOOKUP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    sectValid |-> (sectIdx < sectCount)); // R10

  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !sectValid |-> (sectAddr == '0)); // R10

endmodule

// File: rtl/flash_probe_map.sv
module flash_probe_map
  import flash_probe_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int CNT_W       = 8,
  parameter int WAIT_CYCLES = 100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               probeReq,
  input  logic               lowBoot,
  input  logic [CNT_W-1:0]   sectIdx,
  input  logic [7:0]         flashRdData,
  output logic [ADDR_W-1:0]  flashAddr,
  output logic [7:0]         flashWrData,
  output logic               flashWrEn,
  output logic               flashRdEn,
  output logic               busy,
  output logic               devKnown,
  output logic [CNT_W-1:0]   sectCount,
  output logic [ADDR_W-1:0]  devSize,
  output logic               sectValid,
  output logic [ADDR_W-1:0]  sectAddr
);

  idStrobe_t strobe;
  logic mfrOk;

  probe_ctrl #(.ADDR_W(ADDR_W), .WAIT_CYCLES(WAIT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .probeReq(probeReq), .mfrOk(mfrOk),
    .strobe(strobe), .flashAddr(flashAddr), .flashWrData(flashWrData),
    .flashWrEn(flashWrEn), .flashRdEn(flashRdEn), .busy(busy)
  );

  probe_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .flashRdData(flashRdData),
    .lowBoot(lowBoot), .sectIdx(sectIdx), .mfrOk(mfrOk),
    .devKnown(devKnown), .sectCount(sectCount), .devSize(devSize),
    .sectValid(sectValid), .sectAddr(sectAddr)
  );

endmodule

// File: tb/flash_probe_map_bench.sv
module flash_probe_map_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WAIT_CYC   = 100;

  logic clk = 1'b0;
  logic rstN, probeReq, lowBoot;
  logic [7:0] sectIdx;
  logic [7:0] flashRdData;
  logic [23:0] flashAddr, devSize, sectAddr;
  logic [7:0] flashWrData, sectCount;
  logic flashWrEn, flashRdEn, busy, devKnown, sectValid;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_probe_map #(.WAIT_CYCLES(WAIT_CYC)) u_flash_probe_map (
    .clk(clk), .rstN(rstN), .probeReq(probeReq), .lowBoot(lowBoot),
    .sectIdx(sectIdx), .flashRdData(flashRdData), .flashAddr(flashAddr),
    .flashWrData(flashWrData), .flashWrEn(flashWrEn), .flashRdEn(flashRdEn),
    .busy(busy), .devKnown(devKnown), .sectCount(sectCount), .devSize(devSize),
    .sectValid(sectValid), .sectAddr(sectAddr)
  );

  // flash model
  logic [7:0]  modelMfr, modelDev;
  logic        idMode = 1'b0;
  int          cyc = 0, wrCnt = 0, rd2Cnt = 0, identCnt = 0, exitCnt = 0;
  int          identCyc = 0, rd0Cyc = 0;
  logic [23:0] wrAddrLog [16];
  logic [7:0]  wrDataLog [16];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (flashWrEn) begin
      wrAddrLog[wrCnt % 16] <= flashAddr;
      wrDataLog[wrCnt % 16] <= flashWrData;
      wrCnt <= wrCnt + 1;
      if (flashWrData == 8'h90) begin
        idMode <= 1'b1; identCnt <= identCnt + 1; identCyc <= cyc;
      end
      if (flashWrData == 8'hF0) begin
        idMode <= 1'b0; exitCnt <= exitCnt + 1;
      end
    end
    if (flashRdEn) begin
      if (flashAddr == 24'd0) rd0Cyc <= cyc;
      if (flashAddr == 24'd2) rd2Cnt <= rd2Cnt + 1;
      if (!idMode)                 flashRdData <= 8'hFF;
      else if (flashAddr == 24'd0) flashRdData <= modelMfr;
      else if (flashAddr == 24'd2) flashRdData <= modelDev;
      else                         flashRdData <= 8'h00;
    end
  end

  int nChk = 0, nFail = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input string req, input int idx, input logic expV, input logic [23:0] expA);
    sectIdx = 8'(idx);
    #1;
    chk({req, " valid"}, 32'(sectValid), 32'(expV));
    chk({req, " addr"}, 32'(sectAddr), 32'(expA));
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    chk("R9 probe finishes", 32'(busy), 32'd0);
  endtask

  int w0, r20, id0, ex0;

  task automatic snap();
    w0 = wrCnt; r20 = rd2Cnt; id0 = identCnt; ex0 = exitCnt;
  endtask

  // checks the bus activity of the last probe
  task automatic checkBus(input bit expDevRead);
    chk("R1 write count", 32'(wrCnt - w0), 32'd4);
    chk("R1 first addr", 32'(wrAddrLog[w0 % 16]), 32'h000AAA);
    chk("R1 first data", 32'(wrDataLog[w0 % 16]), 32'hAA);
    chk("R1 second addr", 32'(wrAddrLog[(w0 + 1) % 16]), 32'h000555);
    chk("R1 second data", 32'(wrDataLog[(w0 + 1) % 16]), 32'h55);
    chk("R1 third addr", 32'(wrAddrLog[(w0 + 2) % 16]), 32'h000AAA);
    chk("R1 third data", 32'(wrDataLog[(w0 + 2) % 16]), 32'h90);
    chk("R9 exit addr", 32'(wrAddrLog[(w0 + 3) % 16]), 32'h0);
    chk("R9 exit data", 32'(wrDataLog[(w0 + 3) % 16]), 32'hF0);
    chk("R9 flash in read mode", 32'(idMode), 32'd0);
    chk("R2 wait gap", 32'(rd0Cyc - identCyc > WAIT_CYC), 32'd1);
    chk("R3 device reads", 32'(rd2Cnt - r20), expDevRead ? 32'd1 : 32'd0);
    chk("R11 one ident per probe", 32'(identCnt - id0), 32'd1);
    chk("R9 one exit per probe", 32'(exitCnt - ex0), 32'd1);
  endtask

  task automatic startProbe();
    snap();
    @(negedge clk); probeReq = 1'b1;
    @(negedge clk); probeReq = 1'b0;
  endtask

  task automatic testResetBoot();
    rstN = 1'b0; probeReq = 1'b0; lowBoot = 1'b0; sectIdx = '0;
    modelMfr = 8'h01; modelDev = 8'h49;
    repeat (3) @(negedge clk);
    chk("R11 reset busy", 32'(busy), 32'd0);
    chk("R11 reset known", 32'(devKnown), 32'd0);
    chk("R4 reset count", 32'(sectCount), 32'd0);
    snap();
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 auto probe after reset", 32'(busy), 32'd1);
    waitIdle();
    checkBus(1'b1);
    chk("R5 known", 32'(devKnown), 32'd1);
    chk("R5 count", 32'(sectCount), 32'd35);
    chk("R5 size", 32'(devSize), 32'h200000);
    look("R6 R8 sector0", 0, 1'b1, 24'hE00000);
    look("R6 sector1", 1, 1'b1, 24'hE04000);
    look("R6 sector2", 2, 1'b1, 24'hE06000);
    look("R6 sector3", 3, 1'b1, 24'hE08000);
    look("R6 sector4", 4, 1'b1, 24'hE10000);
    look("R6 sector34", 34, 1'b1, 24'hFF0000);
    look("R10 boot index 35", 35, 1'b0, 24'h0);
    lowBoot = 1'b1;
    look("R8 boot low sector3", 3, 1'b1, 24'h008000);
    look("R8 boot low sector34", 34, 1'b1, 24'h1F0000);
    lowBoot = 1'b0;
  endtask

  task automatic testUniformOverlap();
    modelDev = 8'hC8;
    sectIdx = 8'd5;
    startProbe();
    chk("R11 busy after request", 32'(busy), 32'd1);
    chk("R11 old result cleared", 32'(devKnown), 32'd0);
    look("R10 lookup during probe", 5, 1'b0, 24'h0);
    probeReq = 1'b1;
    @(negedge clk); probeReq = 1'b0;
    waitIdle();
    checkBus(1'b1);
    chk("R7 known", 32'(devKnown), 32'd1);
    chk("R7 count", 32'(sectCount), 32'd128);
    chk("R7 size", 32'(devSize), 32'h800000);
    look("R7 R8 sector0", 0, 1'b1, 24'h800000);
    look("R7 sector1", 1, 1'b1, 24'h810000);
    look("R7 sector127", 127, 1'b1, 24'hFF0000);
    look("R10 uniform index 128", 128, 1'b0, 24'h0);
    look("R10 uniform index 255", 255, 1'b0, 24'h0);
    lowBoot = 1'b1;
    look("R8 uniform low sector127", 127, 1'b1, 24'h7F0000);
    lowBoot = 1'b0;
  endtask

  task automatic testBadMfr();
    modelMfr = 8'h20; modelDev = 8'h49;
    startProbe();
    waitIdle();
    checkBus(1'b0);
    chk("R4 mfr known", 32'(devKnown), 32'd0);
    chk("R4 mfr count", 32'(sectCount), 32'd0);
    chk("R4 mfr size", 32'(devSize), 32'd0);
    look("R4 mfr lookup", 0, 1'b0, 24'h0);
  endtask

  task automatic testBadDev();
    modelMfr = 8'h01; modelDev = 8'h7E;
    startProbe();
    waitIdle();
    checkBus(1'b1);
    chk("R4 dev known", 32'(devKnown), 32'd0);
    chk("R4 dev count", 32'(sectCount), 32'd0);
    chk("R4 dev size", 32'(devSize), 32'd0);
    look("R4 dev lookup", 0, 1'b0, 24'h0);
  endtask

  initial begin
    testResetBoot();
    testUniformOverlap();
    testBadMfr();
    testBadDev();
    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule